// File: doc/BRIEF.md
# Timer-Paced Sample FIFO Audio Channel

This block is one direct-sample audio channel. Software or a DMA engine writes 16-bit words into a byte queue of signed 8-bit samples. Each write stores two samples, the low byte first. The channel has a control word. Its fields enable the left and right outputs, select a volume shift, choose which of two timer overflow pulses paces playback, and give a strobe that flushes the queue. Two copies of the block share one control word. A parameter picks the bit positions each copy decodes.

Each overflow from the selected timer pops one byte into a held output register while the master sound enable is on. The held value stays until the next pop. After a pop, a one-cycle refill request goes to the DMA engine when 16 or fewer bytes remain. The fill count and the full and empty flags are visible at the ports.

Top module: `dsnd_channel`

## Requirements
- R1: A queue write stores two signed bytes: bits 7:0 first, then bits 15:8. Pops return bytes in the order they were stored.
- R2: A write strobe for the lower halfword address and a write strobe for the upper halfword address act as the same push port.
- R3: When the control timer-select bit is 0, only overflow pulse 0 pops. When it is 1, only overflow pulse 1 pops. A pulse from the other timer leaves the count and the held sample unchanged.
- R4: On a pop, the popped byte appears on the sample output in the cycle after the pulse. The sample output holds that value until the next pop.
- R5: In the cycle after a pop, the refill request is high for exactly that cycle if the count is then 16 or fewer. Otherwise it stays low. At all other times it is low.
- R6: With the master enable low, overflow pulses cause no pop and no refill request.
- R7: A control write with the channel's reset bit set empties the queue by the next cycle. The reset bit always reads back as 0.
- R8: Channel 0 decodes control bits 2 (volume shift), 8 (right enable), 9 (left enable), 10 (timer select) and 11 (reset). Channel 1 decodes bits 3, 12, 13, 14 and 15. The readback shows the stored fields at those positions and 0 elsewhere.
- R9: The queue holds 32 bytes. A byte that finds the queue full is dropped. With one slot free, a write keeps its low byte and drops its high byte.
- R10: A pop from an empty queue gives a sample of 0, and the count stays 0.
- R11: The count output gives the number of stored bytes. The full flag is high exactly at 32, and the empty flag is high exactly at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Master sound enable |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_rdata | output | 16 | Control readback for this channel's fields |
| fifo_wr_lo | input | 1 | Queue write, lower halfword address |
| fifo_wr_hi | input | 1 | Queue write, upper halfword address |
| fifo_wdata | input | 16 | Two samples, low byte first |
| tmr_ovf | input | 2 | Overflow pulses from timer 0 and timer 1 |
| sample_out | output | 8 | Held signed sample |
| vol_shift | output | 1 | Volume shift select |
| en_left | output | 1 | Left output enable |
| en_right | output | 1 | Right output enable |
| dma_req | output | 1 | One-cycle refill request |
| fill_count | output | 6 | Bytes held in the queue |
| fifo_full | output | 1 | Queue is full |
| fifo_empty | output | 1 | Queue is empty |

## Verification
A wrong read pointer or a wrong byte order shows up on the sample output in the cycle after the pop that reaches the bad entry. The scoreboard compares every pop against its own model queue, so such an error is reported within that many pops. A bad count or a mishandled boundary shows on the count and flags at once. It also shows later as a refill request at the wrong pop, or as a missing or extra byte when the queue drains. Gating and timer-select errors show as a count change or a request in the cycle after a pulse that should have been ignored.

// File: rtl/dsnd_pkg.sv
// Shared types and field-position helpers for the sample audio channel.
// Assumes two channels that share one 16-bit control word.
package dsnd_pkg;

    typedef struct packed {
        logic vshift;
        logic en_right;
        logic en_left;
        logic tsel;
    } dsnd_ctl_t;

    // Bit position of the volume-shift field for a channel.
    function automatic int unsigned vshift_pos(int unsigned ch);
        return 2 + ch;
    endfunction

    // Lowest bit of the four-bit group (right, left, timer, reset) for a channel.
    function automatic int unsigned grp_base(int unsigned ch);
        return 8 + 4 * ch;
    endfunction

endpackage

// File: rtl/dsnd_ctl_reg.sv
// Control field register for one channel.
// Decodes its fields from the shared control word, using the positions that
// CHAN_IDX selects. The reset field is not stored. It produces a one-cycle
// flush pulse and always reads back as 0.
module dsnd_ctl_reg
    import dsnd_pkg::*;
#(
    parameter int unsigned CHAN_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [15:0]       wdata,
    output dsnd_ctl_t         ctl,
    output logic              flush,
    output logic [15:0]       rdata
);
    localparam int unsigned VS   = vshift_pos(CHAN_IDX);
    localparam int unsigned BASE = grp_base(CHAN_IDX);

    // Load the stored fields on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr) begin
            ctl.vshift   <= wdata[VS];
            ctl.en_right <= wdata[BASE];
            ctl.en_left  <= wdata[BASE+1];
            ctl.tsel     <= wdata[BASE+2];
        end
    end

    // Flush strobe straight from the write.
    assign flush = wr && wdata[BASE+3];

    // Readback places the stored fields at their positions. Everything else reads 0.
    always_comb begin
        rdata          = '0;
        rdata[VS]      = ctl.vshift;
        rdata[BASE]    = ctl.en_right;
        rdata[BASE+1]  = ctl.en_left;
        rdata[BASE+2]  = ctl.tsel;
    end

    // R8
    tsel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata[BASE+2] == $past(wdata[BASE+2])));

endmodule

// File: rtl/dsnd_byte_fifo.sv
// Circular byte queue that takes up to two bytes per cycle and gives one.
// A pop in the same cycle frees space before the push is sized. Bytes that
// find no space are dropped, low byte first in line. Assumes DEPTH is a
// power of two, so the pointers wrap on their own. Flush wins over push.
module dsnd_byte_fifo #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push_en,
    input  logic [15:0]   push_word,
    input  logic          pop,
    output logic [7:0]    pop_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic          pop_ok;
    logic [CW:0]   space;
    logic [1:0]    n_push;
    logic [CW:0]   next_cnt;

    // Work out how many bytes move this cycle.
    always_comb begin
        pop_ok = pop && (count != '0);
        space  = DEPTH_W - {1'b0, count} + {{CW{1'b0}}, pop_ok};
        if (!push_en || flush)
            n_push = 2'd0;
        else if (space >= (CW+1)'(2))
            n_push = 2'd2;
        else if (space == (CW+1)'(1))
            n_push = 2'd1;
        else
            n_push = 2'd0;
        next_cnt = {1'b0, count} - {{CW{1'b0}}, pop_ok} + {{(CW-1){1'b0}}, n_push};
    end

    // Pointer and count update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (pop_ok)
                rd_ptr <= rd_ptr + AW'(1);
            wr_ptr <= wr_ptr + AW'(n_push);
            count  <= next_cnt[CW-1:0];
        end
    end

    // Storage writes, low byte in the first free slot.
    always_ff @(posedge clk) begin
        if (n_push != 2'd0)
            mem[wr_ptr] <= push_word[7:0];
        if (n_push == 2'd2)
            mem[wr_ptr + AW'(1)] <= push_word[15:8];
    end

    // Head byte. An empty queue gives 0.
    assign pop_data = (count != '0) ? mem[rd_ptr] : 8'h00;
    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);

    // R11
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push_en && !flush) |=> empty);
    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/dsnd_pop_sched.sv
// Pop scheduling for one channel.
// Qualifies the selected timer pulse with the master enable, latches the popped
// byte into the held sample, and raises the refill request for the cycle after
// a pop when the post-update count is at or below LOW_MARK.
module dsnd_pop_sched #(
    parameter int unsigned CW       = 6,
    parameter int unsigned LOW_MARK = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_en,
    input  logic [1:0]    tmr_ovf,
    input  logic          tsel,
    input  logic [7:0]    head_data,
    input  logic [CW-1:0] count,
    output logic          pop_evt,
    output logic [7:0]    sample_q,
    output logic          dma_req
);
    logic pop_d;

    // A pop happens only on the chosen timer while the master enable is on.
    assign pop_evt = master_en && tmr_ovf[tsel];

    // Hold the sample and remember that a pop took place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
            pop_d    <= 1'b0;
        end else begin
            pop_d <= pop_evt;
            if (pop_evt)
                sample_q <= head_data;
        end
    end

    // Request uses the count already updated by the pop.
    assign dma_req = pop_d && (count <= CW'(LOW_MARK));

    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !dma_req);
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop_evt |=> $stable(sample_q));
    // R5
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(pop_evt));

endmodule

// File: rtl/dsnd_channel.sv
// One timer-paced sample audio channel: control decode, byte queue and pop
// scheduling. Both halfword write strobes feed the same push port.
module dsnd_channel
    import dsnd_pkg::*;
#(
    parameter int unsigned CHAN_IDX = 0,
    parameter int unsigned DEPTH    = 32,
    parameter int unsigned LOW_MARK = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_en,
    input  logic          ctl_wr,
    input  logic [15:0]   ctl_wdata,
    output logic [15:0]   ctl_rdata,
    input  logic          fifo_wr_lo,
    input  logic          fifo_wr_hi,
    input  logic [15:0]   fifo_wdata,
    input  logic [1:0]    tmr_ovf,
    output logic [7:0]    sample_out,
    output logic          vol_shift,
    output logic          en_left,
    output logic          en_right,
    output logic          dma_req,
    output logic [CW-1:0] fill_count,
    output logic          fifo_full,
    output logic          fifo_empty
);
    dsnd_ctl_t ctl;
    logic      flush, pop_evt;
    logic [7:0] head;

    dsnd_ctl_reg #(.CHAN_IDX(CHAN_IDX)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
        .ctl(ctl), .flush(flush), .rdata(ctl_rdata)
    );

    dsnd_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push_en(fifo_wr_lo || fifo_wr_hi), .push_word(fifo_wdata),
        .pop(pop_evt), .pop_data(head), .count(fill_count),
        .full(fifo_full), .empty(fifo_empty)
    );

    dsnd_pop_sched #(.CW(CW), .LOW_MARK(LOW_MARK)) u_sched (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .tmr_ovf(tmr_ovf),
        .tsel(ctl.tsel), .head_data(head), .count(fill_count),
        .pop_evt(pop_evt), .sample_q(sample_out), .dma_req(dma_req)
    );

    assign vol_shift = ctl.vshift;
    assign en_left   = ctl.en_left;
    assign en_right  = ctl.en_right;

endmodule

// File: tb/test_dsnd_channel.sv
// Scoreboard bench: driver tasks keep a model queue, and a monitor checks
// every cycle after each clock edge.
module test_dsnd_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata, rdata_b;
    logic        fifo_wr_lo = 1'b0, fifo_wr_hi = 1'b0;
    logic [15:0] fifo_wdata = '0;
    logic [1:0]  tmr_ovf = '0;
    logic [7:0]  sample_out, sample_b;
    logic        vol_shift, en_left, en_right, dma_req;
    logic        vs_b, el_b, er_b, req_b, full_b, empty_b;
    logic [5:0]  fill_count, cnt_b;
    logic        fifo_full, fifo_empty;

    int checks = 0;
    int errors = 0;
    byte unsigned model_q[$];
    logic m_tsel = 1'b0;
    logic [7:0] m_sample = 8'h00;
    bit done = 0;

    always #2.5 clk = ~clk;

    dsnd_channel i_dsnd_channel (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .fifo_wr_lo(fifo_wr_lo),
        .fifo_wr_hi(fifo_wr_hi), .fifo_wdata(fifo_wdata), .tmr_ovf(tmr_ovf),
        .sample_out(sample_out), .vol_shift(vol_shift), .en_left(en_left),
        .en_right(en_right), .dma_req(dma_req), .fill_count(fill_count),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    dsnd_channel #(.CHAN_IDX(1)) i_dsnd_channel_b (
        .clk(clk), .rst_n(rst_n), .master_en(1'b0), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(rdata_b), .fifo_wr_lo(1'b0),
        .fifo_wr_hi(1'b0), .fifo_wdata(16'h0), .tmr_ovf(2'b00),
        .sample_out(sample_b), .vol_shift(vs_b), .en_left(el_b),
        .en_right(er_b), .dma_req(req_b), .fill_count(cnt_b),
        .fifo_full(full_b), .fifo_empty(empty_b)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: after each edge, compare sample and request with the model.
    always @(posedge clk) begin
        logic pop_now;
        pop_now = rst_n && master_en && tmr_ovf[m_tsel];
        #1;
        if (rst_n && !done) begin
            if (pop_now) begin
                if (model_q.size() != 0) m_sample = model_q.pop_front();
                else m_sample = 8'h00;
                check("R4 pop sample", int'(sample_out), int'(m_sample));
                check("R5 req after pop", int'(dma_req), int'(model_q.size() <= 16));
            end else begin
                check("R5/R6 no req", int'(dma_req), 0);
                check("R4 hold", int'(sample_out), int'(m_sample));
            end
        end
    end

    task automatic push_word(input bit hi, input logic [15:0] w);
        @(negedge clk);
        fifo_wr_lo = !hi; fifo_wr_hi = hi; fifo_wdata = w;
        if (model_q.size() < 32) model_q.push_back(w[7:0]);
        if (model_q.size() < 32) model_q.push_back(w[15:8]);
        @(negedge clk);
        fifo_wr_lo = 1'b0; fifo_wr_hi = 1'b0;
    endtask

    task automatic ctl_write(input logic [15:0] w);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = w;
        m_tsel = w[10];
        if (w[11]) model_q.delete();
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        tmr_ovf = '0; tmr_ovf[idx] = 1'b1;
        @(negedge clk);
        tmr_ovf = '0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 reset count", int'(fill_count), 0);
        check("R11 reset empty", int'(fifo_empty), 1);
        check("R11 reset full", int'(fifo_full), 0);
        check("R8 reset rdata", int'(ctl_rdata), 0);

        // R8 field layout, channel 0 and channel 1
        ctl_write(16'h0304);
        check("R8 rdata A", int'(ctl_rdata), 16'h0304);
        check("R8 fields A", int'({vol_shift, en_left, en_right}), 3'b111);
        ctl_write(16'hF008);
        check("R8 rdata B", int'(rdata_b), 16'h7008);
        check("R8 A ignores B bits", int'(ctl_rdata), 0);
        ctl_write(16'h0B00);
        check("R7 reset bit reads 0", int'(ctl_rdata), 16'h0300);

        master_en = 1'b1;
        // R1/R2 both addresses push, low byte first
        push_word(0, 16'h8201);
        push_word(1, 16'h7F03);
        check("R2 count after two writes", int'(fill_count), 4);
        repeat (4) pulse(0);
        check("R1 drained", int'(fill_count), 0);

        // R3 wrong timer ignored, then select timer 1
        push_word(1, 16'h5AA5);
        pulse(1);
        check("R3 wrong timer count", int'(fill_count), 2);
        ctl_write(16'h0700);
        pulse(0);
        check("R3 timer0 ignored when tsel=1", int'(fill_count), 2);
        pulse(1);
        check("R3 timer1 pops", int'(fill_count), 1);

        // R6 master enable off
        master_en = 1'b0;
        pulse(1);
        check("R6 no pop when off", int'(fill_count), 1);
        master_en = 1'b1;
        pulse(1);

        // R10 empty pop
        pulse(1);
        check("R10 empty count", int'(fill_count), 0);
        check("R10 empty sample", int'(sample_out), 0);

        // R9/R11 fill to full, overflow, one-slot partial write
        for (int i = 0; i < 16; i++) push_word(i[0], 16'(i * 16'h0203 + 16'h1011));
        check("R11 full count", int'(fill_count), 32);
        check("R11 full flag", int'(fifo_full), 1);
        push_word(0, 16'hEEEE);
        check("R9 drop when full", int'(fill_count), 32);
        pulse(1);
        check("R5 no req at 31", int'(dma_req), 0);
        push_word(0, 16'hC3D4);
        check("R9 partial write", int'(fill_count), 32);
        for (int i = 0; i < 32; i++) pulse(1);
        check("R11 empty after drain", int'(fifo_empty), 1);

        // R7 flush
        push_word(0, 16'h1234);
        push_word(1, 16'h5678);
        ctl_write(16'h0F00);
        check("R7 flush count", int'(fill_count), 0);
        check("R7 flush empty", int'(fifo_empty), 1);
        pulse(1);

        repeat (3) @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule